// File: doc/BRIEF.md
# Opcode-Selected Integer Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It takes two operands of one width and a 4-bit operation code. It returns a result of the same width and a flag that is high when the result is entirely zero. It serves a small integer instruction subset: addition, subtraction, four bitwise logic operations and a signed "less than" test. It holds no state, so a datapath can place it between pipeline registers of its own choosing.

The arithmetic side has one adder. Subtraction feeds that adder the complement of the second operand and a carry-in of one. The less-than test reuses the subtraction. It takes the top bit of the difference as is, with no overflow correction. A final multiplexer picks between the logic side and the arithmetic side according to the operation code. Codes that are not listed below give an all-zero result. Users should treat them as unspecified.

Top module: `opalu_core`

## Requirements
- R1: Code 4'b0000 produces the sum of the two operands, modulo 2^WIDTH.
- R2: Code 4'b0010 produces the first operand minus the second, modulo 2^WIDTH.
- R3: Code 4'b0100 produces the bitwise AND of the operands.
- R4: Code 4'b0101 produces the bitwise OR of the operands.
- R5: Code 4'b0110 produces the bitwise exclusive OR of the operands.
- R6: Code 4'b0111 produces the bitwise NOR of the operands.
- R7: Code 4'b1010 puts the most significant bit of (first minus second) in result bit 0, and every higher result bit is zero.
- R8: The less-than result makes no overflow correction. With first = 32'h8000_0000 and second = 32'h0000_0001 the result is 0, and with first = 32'h7FFF_FFFF and second = 32'hFFFF_FFFF it is 1.
- R9: The zero flag is 1 exactly when all result bits are 0, for every defined code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| op_sel_i | input | 4 | Operation code |
| res_o | output | 32 | Operation result |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
The embedded checks assume that the operand and code inputs are known, driven values. They are evaluated only after the combinational paths have settled on those values. They also assume that an undefined code carries no meaning, so they say nothing about its result. The stimulus drives only the seven listed codes, with fully defined operands. It changes the inputs once per cycle on one clock edge and samples on the opposite edge. The operands are the corner values zero, all ones, the largest positive number and the most negative number, plus random pairs and equal pairs, so that zero results appear often.

// File: rtl/opalu_pkg.sv
package opalu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD  = 4'b0000,
        OPC_SUB  = 4'b0010,
        OPC_AND  = 4'b0100,
        OPC_OR   = 4'b0101,
        OPC_XOR  = 4'b0110,
        OPC_NOR  = 4'b0111,
        OPC_SLT  = 4'b1010
    } opcode_e;

    // Selector for the bitwise unit, taken from the low code bits
    typedef enum logic [1:0] {
        LOG_AND = 2'b00,
        LOG_OR  = 2'b01,
        LOG_XOR = 2'b10,
        LOG_NOR = 2'b11
    } logic_sel_e;
endpackage

// File: rtl/opalu_bitwise.sv
module opalu_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]       a_i,
    input  logic [WIDTH-1:0]       b_i,
    input  opalu_pkg::logic_sel_e  sel_i,
    output logic [WIDTH-1:0]       y_o
);
    import opalu_pkg::*;

    logic [WIDTH-1:0] y_d;

    // Per-bit cell so each output bit is a 2-input function plus a 4:1 pick
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        always_comb begin
            unique case (sel_i)
                LOG_AND: y_d[gi] = a_i[gi] & b_i[gi];
                LOG_OR:  y_d[gi] = a_i[gi] | b_i[gi];
                LOG_XOR: y_d[gi] = a_i[gi] ^ b_i[gi];
                default: y_d[gi] = ~(a_i[gi] | b_i[gi]);
            endcase
        end
    end

    assign y_o = y_d;

    // R6: a NOR result never shares a set bit with either operand
    always_comb begin
        if (sel_i == LOG_NOR) begin
            a_r6_nor_disjoint: assert ((y_o & (a_i | b_i)) == '0);
        end
    end
endmodule

// File: rtl/opalu_adder.sv
module opalu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             neg_b_i,
    output logic [WIDTH-1:0] sum_o
);
    logic [WIDTH-1:0] b_eff_d;
    logic             cin_d;

    always_comb begin
        b_eff_d = neg_b_i ? ~b_i : b_i;
        cin_d   = neg_b_i;
    end

    assign sum_o = a_i + b_eff_d + {{(WIDTH-1){1'b0}}, cin_d};

    // R1 / R2: undoing the operation on the output recovers the first operand
    always_comb begin
        if (!neg_b_i) begin
            a_r1_add_inverse: assert ((sum_o - b_i) == a_i);
        end else begin
            a_r2_sub_inverse: assert ((sum_o + b_i) == a_i);
        end
    end
endmodule

// File: rtl/opalu_zero.sv
module opalu_zero #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] v_i,
    output logic             zero_o
);
    assign zero_o = ~|v_i;
endmodule

// File: rtl/opalu_core.sv
module opalu_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [3:0]       op_sel_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o
);
    import opalu_pkg::*;

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             neg_b;
        logic_sel_e       lsel;
    } ctl_t;

    ctl_t             ctl_d;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] logic_w;
    logic             zero_w;

    // Code bit 1 picks the inverted second operand (sub and less-than)
    always_comb begin
        ctl_d.neg_b = op_sel_i[1];
        ctl_d.lsel  = logic_sel_e'(op_sel_i[1:0]);
    end

    opalu_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .neg_b_i (ctl_d.neg_b),
        .sum_o   (sum_w)
    );

    opalu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sel_i (ctl_d.lsel),
        .y_o   (logic_w)
    );

    // Result multiplexer; unlisted codes give zero so no X escapes
    always_comb begin
        unique case (op_sel_i)
            OPC_ADD, OPC_SUB:                   ctl_d.res = sum_w;
            OPC_AND, OPC_OR, OPC_XOR, OPC_NOR:  ctl_d.res = logic_w;
            OPC_SLT:                            ctl_d.res = {{(WIDTH-1){1'b0}}, sum_w[MSB]};
            default:                            ctl_d.res = '0;
        endcase
    end

    opalu_zero #(.WIDTH(WIDTH)) u_zero (
        .v_i    (ctl_d.res),
        .zero_o (zero_w)
    );

    assign res_o  = ctl_d.res;
    assign zero_o = zero_w;

    // R7: less-than leaves every upper result bit clear
    always_comb begin
        if (op_sel_i == OPC_SLT) begin
            a_r7_slt_upper_clear: assert (res_o[MSB:1] == '0);
        end
    end

    // R9: flag and result agree in both directions
    always_comb begin
        if (zero_o) begin
            a_r9_zero_means_clear: assert (res_o == '0);
        end else begin
            a_r9_clear_means_zero: assert (res_o != '0);
        end
    end
endmodule

// File: tb/opalu_core_tb.sv
module opalu_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] res;
        logic         zero;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b;
    logic [3:0]   op;
    logic [W-1:0] res;
    logic         zero;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    opalu_core #(.WIDTH(W)) u_dut (
        .opa_i    (a),
        .opb_i    (b),
        .op_sel_i (op),
        .res_o    (res),
        .zero_o   (zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic exp_t model(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
        exp_t e;
        logic [W-1:0] d;
        d = x - y;
        case (o)
            4'b0000: begin e.res = x + y;    e.tag = "R1"; end
            4'b0010: begin e.res = d;        e.tag = "R2"; end
            4'b0100: begin e.res = x & y;    e.tag = "R3"; end
            4'b0101: begin e.res = x | y;    e.tag = "R4"; end
            4'b0110: begin e.res = x ^ y;    e.tag = "R5"; end
            4'b0111: begin e.res = ~(x | y); e.tag = "R6"; end
            default: begin e.res = {31'd0, d[W-1]}; e.tag = "R7"; end
        endcase
        e.zero = (e.res == 0);
        return e;
    endfunction

    // Driver: apply on the rising edge, push the expectation
    task automatic drive(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y, string tag_ovr = "");
        exp_t e;
        @(posedge clk);
        op = o; a = x; b = y;
        e = model(o, x, y);
        if (tag_ovr != "") e.tag = tag_ovr;
        sb.push_back(e);
    endtask

    // Monitor: sample on the falling edge, pop and compare
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (res !== e.res) begin
                errors++;
                $display("FAIL %s result actual=%h expected=%h (op=%b a=%h b=%h)",
                         e.tag, res, e.res, op, a, b);
            end
            checks++;
            if (zero !== e.zero) begin
                errors++;
                $display("FAIL R9 zero actual=%b expected=%b (op=%b res=%h)",
                         zero, e.zero, op, res);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corners [4];
        logic [3:0]   ops [7];
        corners = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
        ops = '{4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1010};
        op = 4'b0000; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-state check: idle inputs give a zero sum with flag high (R1, R9)
        drive(4'b0000, 32'h0, 32'h0, "R1");
        // R8: no overflow correction on less-than
        drive(4'b1010, 32'h8000_0000, 32'h0000_0001, "R8");
        drive(4'b1010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R8");
        // R2 / R7 on equal operands: zero difference and clear less-than
        drive(4'b0010, 32'h1234_5678, 32'h1234_5678, "R2");
        drive(4'b1010, 32'h5, 32'h5, "R7");
        drive(4'b1010, 32'h3, 32'h9, "R7");
        // R1 wrap to zero
        drive(4'b0000, 32'hFFFF_FFFF, 32'h1, "R1");
        // Corner grid over every defined code
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 4; j++)
                for (int k = 0; k < 4; k++)
                    drive(ops[i], corners[j], corners[k]);
        // Random pairs, with some equal pairs so zero results occur
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] x, y;
            x = $urandom;
            y = (n % 5 == 0) ? x : $urandom;
            drive(ops[n % 7], x, y);
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule